// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns one instruction, of one or two 16-bit words, into the operand address for a word-addressed machine with a 16K-word memory. It reads the layout of the first word, picks a base register, adds the displacement and wraps the sum into the 14-bit address space. The instruction sequencer supplies the first word, the second word (used only by the two-word format), the current instruction address and three general index registers. It pulses `start_i` to request an address and receives the address, the instruction length in words and a one-cycle `done_o`.

Short-format instructions use a signed 8-bit displacement, taken relative to the following instruction or to an index register. Long-format instructions carry an absolute address in their second word, and an index register may be added to it. A set top bit in the second word makes the address indirect. The block then makes a single read on a request/valid memory port, and the low 14 bits of the returned word become the operand address. The block ignores any start that arrives while that read is outstanding.

Top module: `operand_addr_unit`

## Requirements
- R1: Bit 0 of a word is its most significant bit. In word 0, bits 0-4 (vector [15:11]) are the operation code and have no effect on the address. Bit 5 ([10]) selects long format when it is 1. Bits 6-7 ([9:8]) are the register tag, and bits 8-15 ([7:0]) are the displacement.
- R2: For a short instruction with tag 00, the address is (IAR + 1 + signed displacement) mod 16384.
- R3: For a short instruction with tags 01, 10 or 11, the address is (XR1, XR2 or XR3 + signed displacement) mod 16384.
- R4: For a long instruction with [15] of word 1 equal to 0, the address is (word1[13:0] + index) mod 16384. The index is 0 for tag 00 and XR1 to XR3 for tags 01 to 11. Word 1 bit [14] is ignored.
- R5: For a direct instruction, `done_o` is high in the same cycle as an accepted `start_i`. `ilen_o` is 1 for short format and 2 for long format.
- R6: For a long instruction with word1[15] equal to 1, exactly one `mem_req_o` pulse is issued, in the cycle after the start. It carries the R4 address on `mem_addr_o`, and `done_o` stays low in the start cycle.
- R7: `done_o` pulses for one cycle, in the cycle after `mem_valid_i` is sampled high, with `ea_o` = `mem_rdata_i[13:0]` and `ilen_o` = 2.
- R8: While an indirect read is outstanding, `start_i` causes neither a `done_o` nor a further `mem_req_o`.
- R9: While and after reset, `done_o` and `mem_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Request an address for the presented instruction |
| instr_w0_i | input | 16 | First instruction word |
| instr_w1_i | input | 16 | Second instruction word (long format) |
| iar_i | input | 14 | Address of the current instruction |
| xr1_i | input | 14 | Index register 1 |
| xr2_i | input | 14 | Index register 2 |
| xr3_i | input | 14 | Index register 3 |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Read data (pointer word) |
| ea_o | output | 14 | Effective address |
| ilen_o | output | 2 | Instruction length in words |
| done_o | output | 1 | Address valid strobe |
| mem_req_o | output | 1 | Pointer read request |
| mem_addr_o | output | 14 | Pointer read address |

## Verification
The bench sweeps every displacement under every tag, using base values that straddle the top of the address space. A design that zero-extended the displacement, or did not wrap, would produce addresses off by 256 or outside 16K. A design that used IAR rather than IAR+1 for tag 00 would be off by one on every short relative case. The long sweep sets the ignored bit 14 and the opcode bits, and it shows whether a long tag 00 wrongly adds the IAR. The indirect cases vary the read latency from zero to three cycles and poke `start_i` mid-fetch. A design that re-issued the request, finished early, or accepted the second start would show an extra request, a premature or missing strobe, or a wrong length.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 14;
  localparam int DISP_W = 8;
  localparam int TAG_W  = 2;
  localparam int OPC_W  = WORD_W - 1 - TAG_W - DISP_W;

  // Field order is behaviour: first field is word bit 0 (the MSB).
  typedef struct packed {
    logic [OPC_W-1:0]  opcode;
    logic              long_fmt;
    logic [TAG_W-1:0]  tag;
    logic [DISP_W-1:0] disp;
  } iword_t;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2,
    FS_FIN  = 2'd3
  } fetch_st_e;

  // Sign-extend the displacement into the address width.
  function automatic logic [ADDR_W-1:0] disp_sext(input logic [DISP_W-1:0] d);
    return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  // Address addition that wraps modulo the address space.
  function automatic logic [ADDR_W-1:0] addr_sum(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] b);
    return a + b;
  endfunction
endpackage

// File: rtl/ea_field_decode.sv
module ea_field_decode
  import ea_pkg::*;
(
  input  logic [WORD_W-1:0] w0_i,
  input  logic [WORD_W-1:0] w1_i,
  output logic              long_fmt_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [ADDR_W-1:0] disp_o,
  output logic [ADDR_W-1:0] abs_addr_o,
  output logic              indirect_o
);
  iword_t fields;
  logic   unused_bits;

  assign fields      = iword_t'(w0_i);
  assign long_fmt_o  = fields.long_fmt;
  assign tag_o       = fields.tag;
  assign disp_o      = disp_sext(fields.disp);
  assign abs_addr_o  = w1_i[ADDR_W-1:0];
  assign indirect_o  = fields.long_fmt & w1_i[WORD_W-1];
  assign unused_bits = ^{fields.opcode, w1_i[WORD_W-2:ADDR_W]};
endmodule

// File: rtl/ea_base_select.sv
module ea_base_select
  import ea_pkg::*;
(
  input  logic [ADDR_W-1:0] iar_i,
  input  logic [ADDR_W-1:0] xr1_i,
  input  logic [ADDR_W-1:0] xr2_i,
  input  logic [ADDR_W-1:0] xr3_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              long_fmt_i,
  output logic [ADDR_W-1:0] base_o
);
  localparam int NUM_REG = 1 << TAG_W;

  logic [ADDR_W-1:0] reg_tab [NUM_REG];
  logic [ADDR_W-1:0] next_iar;

  assign next_iar = addr_sum(iar_i, ADDR_W'(1));

  // Slot 0: the following instruction for short format, no index for long.
  assign reg_tab[0] = long_fmt_i ? '0 : next_iar;
  assign reg_tab[1] = xr1_i;
  assign reg_tab[2] = xr2_i;
  assign reg_tab[3] = xr3_i;

  assign base_o = reg_tab[tag_i];
endmodule

// File: rtl/ea_indirect_fetch.sv
module ea_indirect_fetch
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] ptr_addr_i,
  input  logic              mem_valid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              idle_o,
  output logic              fin_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] ptr_o
);
  fetch_st_e         st_q, st_d;
  logic [ADDR_W-1:0] addr_q, ptr_q;
  logic              waiting, capture;
  logic              unused_rdata;

  assign waiting      = (st_q == FS_REQ) || (st_q == FS_WAIT);
  assign capture      = waiting && mem_valid_i;
  assign unused_rdata = ^mem_rdata_i[WORD_W-1:ADDR_W];

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FS_IDLE: if (launch_i) st_d = FS_REQ;
      FS_REQ:  st_d = mem_valid_i ? FS_FIN : FS_WAIT;
      FS_WAIT: if (mem_valid_i) st_d = FS_FIN;
      FS_FIN:  st_d = FS_IDLE;
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      addr_q <= '0;
      ptr_q  <= '0;
    end else begin
      st_q <= st_d;
      if (launch_i && st_q == FS_IDLE) addr_q <= ptr_addr_i;
      if (capture) ptr_q <= mem_rdata_i[ADDR_W-1:0];
    end
  end

  assign idle_o     = (st_q == FS_IDLE);
  assign fin_o      = (st_q == FS_FIN);
  assign mem_req_o  = (st_q == FS_REQ);
  assign mem_addr_o = addr_q;
  assign ptr_o      = ptr_q;

  assert_single_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);
  assert_req_follows_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> $past(launch_i));
  assert_fin_after_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> fin_o);
  assert_fin_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o);
endmodule

// File: rtl/operand_addr_unit.sv
module operand_addr_unit
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [15:0]       instr_w0_i,
  input  logic [15:0]       instr_w1_i,
  input  logic [13:0]       iar_i,
  input  logic [13:0]       xr1_i,
  input  logic [13:0]       xr2_i,
  input  logic [13:0]       xr3_i,
  input  logic              mem_valid_i,
  input  logic [15:0]       mem_rdata_i,
  output logic [13:0]       ea_o,
  output logic [1:0]        ilen_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic [13:0]       mem_addr_o
);
  logic              long_fmt, indirect, fetch_idle, fetch_fin;
  logic [TAG_W-1:0]  tag;
  logic [ADDR_W-1:0] disp, abs_addr, base, ea_direct, ptr;
  logic              accept, launch, direct_done;

  ea_field_decode u_decode (
    .w0_i       (instr_w0_i),
    .w1_i       (instr_w1_i),
    .long_fmt_o (long_fmt),
    .tag_o      (tag),
    .disp_o     (disp),
    .abs_addr_o (abs_addr),
    .indirect_o (indirect)
  );

  ea_base_select u_base (
    .iar_i      (iar_i),
    .xr1_i      (xr1_i),
    .xr2_i      (xr2_i),
    .xr3_i      (xr3_i),
    .tag_i      (tag),
    .long_fmt_i (long_fmt),
    .base_o     (base)
  );

  assign ea_direct = addr_sum(base, long_fmt ? abs_addr : disp);

  // Named events for the checks below.
  assign accept      = start_i && fetch_idle;
  assign launch      = accept && indirect;
  assign direct_done = accept && !indirect;

  ea_indirect_fetch u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_i    (launch),
    .ptr_addr_i  (ea_direct),
    .mem_valid_i (mem_valid_i),
    .mem_rdata_i (mem_rdata_i),
    .idle_o      (fetch_idle),
    .fin_o       (fetch_fin),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .ptr_o       (ptr)
  );

  assign done_o = direct_done || fetch_fin;
  assign ea_o   = fetch_fin ? ptr : ea_direct;
  assign ilen_o = (fetch_fin || long_fmt) ? 2'd2 : 2'd1;

  assert_len_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ilen_o == 2'd1 || ilen_o == 2'd2));
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !fetch_idle) |=> !mem_req_o);
  assert_launch_no_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !done_o);
  always_comb begin
    if (!rst_n) assert_reset_quiet_R9: assert (!mem_req_o);
  end
endmodule

// File: tb/operand_addr_unit_bench.sv
`timescale 1ns/1ps
module operand_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] instr_w0_i = '0, instr_w1_i = '0;
  logic [13:0] iar_i = '0, xr1_i = '0, xr2_i = '0, xr3_i = '0;
  logic        mem_valid_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;
  logic [13:0] ea_o, mem_addr_o;
  logic [1:0]  ilen_o;
  logic        done_o, mem_req_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  operand_addr_unit u_operand_addr_unit (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wrap(input int v);
    return ((v % 16384) + 16384) % 16384;
  endfunction

  function automatic int xr_of(input int t);
    case (t)
      1: return int'(xr1_i);
      2: return int'(xr2_i);
      3: return int'(xr3_i);
      default: return 0;
    endcase
  endfunction

  // Direct instruction: one cycle, checked combinationally in the start cycle.
  task automatic run_direct(input logic [15:0] w0, input logic [15:0] w1,
                            input int exp_ea, input int exp_len, input string req);
    @(negedge clk);
    instr_w0_i = w0; instr_w1_i = w1; start_i = 1'b1;
    #1;
    chk(req, int'(done_o), 1);
    chk(req, int'(ea_o), exp_ea);
    chk("R5", int'(ilen_o), exp_len);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_indirect(input int t, input int w1addr, input int ptr_word,
                              input int lat, input bit poke);
    int reqs;
    logic [15:0] w0;
    w0 = {5'b10110, 1'b1, 2'(t), 8'h00};
    reqs = 0;
    @(negedge clk);
    instr_w0_i = w0; instr_w1_i = 16'h8000 | 16'(w1addr); start_i = 1'b1;
    #1;
    chk("R6", int'(done_o), 0);
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk("R6", int'(mem_req_o), 1);
    chk("R6", int'(mem_addr_o), wrap(w1addr % 16384 + xr_of(t)));
    reqs++;
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      if (poke && k == 0) begin
        instr_w0_i = 16'h0005; start_i = 1'b1;
      end else begin
        start_i = 1'b0; instr_w0_i = w0;
      end
      #1;
      if (mem_req_o) reqs++;
      chk("R8", int'(done_o), 0);
    end
    start_i = 1'b0; instr_w0_i = w0;
    mem_valid_i = 1'b1; mem_rdata_i = 16'(ptr_word);
    @(negedge clk);
    mem_valid_i = 1'b0; mem_rdata_i = 16'hFFFF;
    #1;
    if (mem_req_o) reqs++;
    chk("R7", int'(done_o), 1);
    chk("R7", int'(ea_o), ptr_word % 16384);
    chk("R7", int'(ilen_o), 2);
    chk("R8", reqs, 1);
    @(negedge clk);
    #1;
    chk("R7", int'(done_o), 0);
    chk("R8", int'(mem_req_o), 0);
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int bases[2];
    int longs[6];
    bases[0] = 16'h3FF8; bases[1] = 16'h0003;
    longs[0] = 0; longs[1] = 1; longs[2] = 16'h1FFF;
    longs[3] = 16'h3FFF; longs[4] = 16'h7FFE; longs[5] = 16'h4000;
    #1;
    chk("R9", int'(done_o), 0);
    chk("R9", int'(mem_req_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9", int'(done_o), 0);
    chk("R9", int'(mem_req_o), 0);

    // Short format: every displacement, every tag, bases near both ends.
    foreach (bases[b]) begin
      iar_i = 14'(bases[b]);
      xr1_i = 14'(bases[b] + 5);
      xr2_i = 14'h3FFF;
      xr3_i = 14'h0080;
      for (int t = 0; t < 4; t++) begin
        for (int d = 0; d < 256; d++) begin
          int sd, base, opc;
          sd = (d >= 128) ? d - 256 : d;
          base = (t == 0) ? int'(iar_i) + 1 : xr_of(t);
          opc = (d * 7 + t) % 32;
          run_direct({5'(opc), 1'b0, 2'(t), 8'(d)}, 16'hFFFF, wrap(base + sd), 1,
                     (t == 0) ? "R2" : "R3");
        end
      end
    end

    // Long direct: bit 14 of word 1 and the opcode must not matter (R1, R4).
    iar_i = 14'h1111; xr1_i = 14'h0001; xr2_i = 14'h2000; xr3_i = 14'h3FFF;
    for (int t = 0; t < 4; t++) begin
      foreach (longs[i]) begin
        run_direct({5'b11111, 1'b1, 2'(t), 8'hA5}, 16'(longs[i]),
                   wrap(longs[i] % 16384 + xr_of(t)), 2, "R4");
      end
    end

    // Indirect: latencies 0..3, with a start poked during the fetch.
    for (int lat = 0; lat < 4; lat++) begin
      for (int t = 0; t < 4; t++) begin
        run_indirect(t, 16'h3FF0 + lat, 16'hC000 | (lat * 257 + t), lat, lat > 0);
      end
    end

    // Right after an indirect fetch, a direct start completes at once (R5).
    run_direct({5'b00000, 1'b0, 2'b00, 8'hFF}, 16'h0000, int'(iar_i), 1, "R5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule